// File: doc/BRIEF.md
# Interrupt and Break Entry Sequencer

This block runs the fixed bus sequence a small 8-bit processor core uses to enter a software break or a hardware interrupt (maskable request, non-maskable request, reset). Once started at an instruction boundary, it runs seven bus cycles. The first two are dummy reads at the program counter. The next three are stack cycles, which save the return address high byte first, then the low byte, then the status byte. The last two are reads of the new program counter from a vector, low byte first. It then pulses a completion strobe and presents the new program counter, stack pointer and flag byte to the core.

A mode pin selects between the older and the newer behaviour. In the older mode, a non-maskable request that arrives while a break is in progress steals the break's vector. In the newer mode, every entry also clears the decimal flag. Requests are only taken when they have been seen for a full clock cycle before the boundary.

Top module: `intr_entry_seq`

## Requirements
- R1: Every stack cycle addresses 0x0100 combined with the 8-bit stack pointer. The pointer decrements once per stack cycle and wraps from 0x00 to 0xFF, so it ends three lower than where it started.
- R2: Stack cycles store the return address high byte, then its low byte, then the status byte. The second dummy read is at the program counter plus one for a break and at the unchanged counter otherwise. The return address is the start counter plus two for a break and the start counter itself for hardware entries.
- R3: The saved status byte is the incoming flag byte with bit 5 forced to 1. Bit 4 is 1 for a break and 0 for any hardware entry.
- R4: Every entry sets the interrupt-mask flag (bit 2). In the newer mode (cmos_mode=1) every entry clears the decimal flag (bit 3). In the older mode bit 3 is kept.
- R5: The vector is 0xFFFA for non-maskable requests, 0xFFFC for reset, and 0xFFFE for maskable requests and breaks. It is read low byte at the vector address, then high byte at the vector address plus one.
- R6: In the older mode, a non-maskable request pending when a break reaches its status cycle redirects the break to 0xFFFA and is consumed. In the newer mode the break keeps 0xFFFE and the request stays pending for the next boundary.
- R7: A request first seen in the same cycle as the boundary is not taken in that cycle.
- R8: The maskable request is level-sensitive (irq_n low) and is ignored while flags_in bit 2 is set. The non-maskable request is latched on a falling edge of nmi_n.
- R9: A reset entry performs its three stack cycles as reads (rw=1) at the stack addresses.
- R10: Priority at a boundary is reset, then non-maskable, then maskable, then break. Lower-priority requests remain pending. brk_start has no effect without insn_boundary.
- R11: done is high for exactly one cycle, the cycle after the final vector read, with pc_out, s_out and flags_out valid. While not busy the bus shows a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| brk_start | input | 1 | Break instruction ready to enter |
| irq_n | input | 1 | Maskable request, active low level |
| nmi_n | input | 1 | Non-maskable request, falling edge |
| reset_req | input | 1 | Reset entry request |
| cmos_mode | input | 1 | 1 selects newer behaviour |
| pc_in | input | 16 | Program counter at entry start |
| s_in | input | 8 | Stack pointer at entry start |
| flags_in | input | 8 | Flag byte at entry start |
| din | input | 8 | Read data from memory |
| addr | output | 16 | Bus address |
| dout | output | 8 | Write data |
| rw | output | 1 | 1 read, 0 write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| pc_out | output | 16 | New program counter |
| s_out | output | 8 | New stack pointer |
| flags_out | output | 8 | New flag byte |

## Verification
A request that is pending for one cycle before the boundary starts the sequence at the next edge. The first bus cycle is visible one cycle after the boundary edge, and each further bus cycle follows one clock later. done and the new state appear in the eighth cycle after the start edge. The bench builds the seven expected bus cycles of each entry in a queue and compares one entry every clock at the falling edge. It drives read data in the same half cycle so that it is captured at the next rising edge. Cases that must not start an entry are checked one and two cycles after the boundary. Deferred requests are checked by starting a further boundary and comparing the full trace of the entry that follows.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;

    typedef enum logic [2:0] {
        PH_IDLE, PH_T1, PH_T2, PH_T3, PH_T4, PH_T5, PH_T6, PH_T7
    } phase_e;

    typedef enum logic [1:0] {
        K_BRK, K_IRQ, K_NMI, K_RST
    } kind_e;

    localparam int FL_I = 2;
    localparam int FL_D = 3;
    localparam int FL_B = 4;
    localparam int FL_U = 5;

endpackage

// File: rtl/intr_req_latch.sv
module intr_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic irq_n,
    input  logic reset_req,
    input  logic nmi_clr,
    input  logic rst_clr,
    output logic nmi_pend,
    output logic irq_pend,
    output logic rst_pend
);
    typedef struct packed {
        logic nmi_prev;
        logic nmi_pend;
        logic irq_lvl;
        logic rst_pend;
    } req_t;

    req_t req_d, req_q;

    always_comb begin
        req_d          = req_q;
        req_d.nmi_prev = nmi_n;
        // a fresh falling edge wins over a clear in the same cycle
        req_d.nmi_pend = (req_q.nmi_pend & ~nmi_clr) | (req_q.nmi_prev & ~nmi_n);
        req_d.irq_lvl  = ~irq_n;
        req_d.rst_pend = reset_req | (req_q.rst_pend & ~rst_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '{nmi_prev: 1'b1, nmi_pend: 1'b0, irq_lvl: 1'b0, rst_pend: 1'b0};
        end else begin
            req_q <= req_d;
        end
    end

    assign nmi_pend = req_q.nmi_pend;
    assign irq_pend = req_q.irq_lvl;
    assign rst_pend = req_q.rst_pend;
endmodule

// File: rtl/intr_vec_sel.sv
module intr_vec_sel
    import intr_entry_pkg::*;
#(
    parameter int             AW      = 16,
    parameter logic [AW-1:0]  VEC_NMI = 16'hFFFA,
    parameter logic [AW-1:0]  VEC_RST = 16'hFFFC,
    parameter logic [AW-1:0]  VEC_IRQ = 16'hFFFE
) (
    input  kind_e          kind,
    input  logic           cmos_mode,
    input  logic           nmi_pend,
    output logic [AW-1:0]  vec,
    output logic           take_nmi
);
    always_comb begin
        take_nmi = (kind == K_BRK) && !cmos_mode && nmi_pend;
        unique case (kind)
            K_RST:   vec = VEC_RST;
            K_NMI:   vec = VEC_NMI;
            K_IRQ:   vec = VEC_IRQ;
            default: vec = take_nmi ? VEC_NMI : VEC_IRQ;
        endcase
    end
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
    import intr_entry_pkg::*;
#(
    parameter int                 AW         = 16,
    parameter int                 DW         = 8,
    parameter logic [AW-DW-1:0]   STACK_PAGE = 'h01,
    parameter logic [AW-1:0]      VEC_NMI    = 16'hFFFA,
    parameter logic [AW-1:0]      VEC_RST    = 16'hFFFC,
    parameter logic [AW-1:0]      VEC_IRQ    = 16'hFFFE
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           insn_boundary,
    input  logic           brk_start,
    input  logic           irq_n,
    input  logic           nmi_n,
    input  logic           reset_req,
    input  logic           cmos_mode,
    input  logic [AW-1:0]  pc_in,
    input  logic [DW-1:0]  s_in,
    input  logic [DW-1:0]  flags_in,
    input  logic [DW-1:0]  din,
    output logic [AW-1:0]  addr,
    output logic [DW-1:0]  dout,
    output logic           rw,
    output logic           busy,
    output logic           done,
    output logic [AW-1:0]  pc_out,
    output logic [DW-1:0]  s_out,
    output logic [DW-1:0]  flags_out
);
    typedef struct packed {
        phase_e         phase;
        kind_e          kind;
        logic [AW-1:0]  pc;
        logic [DW-1:0]  s;
        logic [DW-1:0]  flags;
        logic [AW-1:0]  vec;
        logic           done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          nmi_pend, irq_pend, rst_pend;
    logic          nmi_clr, rst_clr, take_nmi;
    logic [AW-1:0] vec_pick;

    intr_req_latch u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi_n     (nmi_n),
        .irq_n     (irq_n),
        .reset_req (reset_req),
        .nmi_clr   (nmi_clr),
        .rst_clr   (rst_clr),
        .nmi_pend  (nmi_pend),
        .irq_pend  (irq_pend),
        .rst_pend  (rst_pend)
    );

    intr_vec_sel #(
        .AW      (AW),
        .VEC_NMI (VEC_NMI),
        .VEC_RST (VEC_RST),
        .VEC_IRQ (VEC_IRQ)
    ) u_vec (
        .kind      (seq_q.kind),
        .cmos_mode (cmos_mode),
        .nmi_pend  (nmi_pend),
        .vec       (vec_pick),
        .take_nmi  (take_nmi)
    );

    logic          go;
    kind_e         kind_sel;
    logic [DW-1:0] status;
    logic [AW-1:0] stack_addr;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        addr       = '0;
        dout       = '0;
        rw         = 1'b1;
        nmi_clr    = 1'b0;
        rst_clr    = 1'b0;
        go         = 1'b0;
        kind_sel   = K_BRK;

        status        = seq_q.flags;
        status[FL_B]  = (seq_q.kind == K_BRK);
        status[FL_U]  = 1'b1;
        stack_addr    = {STACK_PAGE, seq_q.s};

        unique case (seq_q.phase)
            PH_IDLE: begin
                if (insn_boundary) begin
                    if (rst_pend) begin
                        go = 1'b1; kind_sel = K_RST; rst_clr = 1'b1;
                    end else if (nmi_pend) begin
                        go = 1'b1; kind_sel = K_NMI; nmi_clr = 1'b1;
                    end else if (irq_pend && !flags_in[FL_I]) begin
                        go = 1'b1; kind_sel = K_IRQ;
                    end else if (brk_start) begin
                        go = 1'b1; kind_sel = K_BRK;
                    end
                end
                if (go) begin
                    seq_d.phase = PH_T1;
                    seq_d.kind  = kind_sel;
                    seq_d.pc    = pc_in;
                    seq_d.s     = s_in;
                    seq_d.flags = flags_in;
                end
            end
            PH_T1, PH_T2: begin
                addr = seq_q.pc;
                if (seq_q.kind == K_BRK) seq_d.pc = seq_q.pc + AW'(1);
                seq_d.phase = (seq_q.phase == PH_T1) ? PH_T2 : PH_T3;
            end
            PH_T3: begin
                addr        = stack_addr;
                rw          = (seq_q.kind == K_RST);
                dout        = seq_q.pc[AW-1:DW];
                seq_d.s     = seq_q.s - DW'(1);
                seq_d.phase = PH_T4;
            end
            PH_T4: begin
                addr        = stack_addr;
                rw          = (seq_q.kind == K_RST);
                dout        = seq_q.pc[DW-1:0];
                seq_d.s     = seq_q.s - DW'(1);
                seq_d.phase = PH_T5;
            end
            PH_T5: begin
                addr        = stack_addr;
                rw          = (seq_q.kind == K_RST);
                dout        = status;
                seq_d.s     = seq_q.s - DW'(1);
                seq_d.vec   = vec_pick;
                nmi_clr     = take_nmi;
                seq_d.flags[FL_I] = 1'b1;
                if (cmos_mode) seq_d.flags[FL_D] = 1'b0;
                seq_d.phase = PH_T6;
            end
            PH_T6: begin
                addr               = seq_q.vec;
                seq_d.pc[DW-1:0]   = din;
                seq_d.phase        = PH_T7;
            end
            default: begin
                addr               = seq_q.vec + AW'(1);
                seq_d.pc[AW-1:DW]  = din;
                seq_d.done         = 1'b1;
                seq_d.phase        = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_IDLE, kind: K_BRK, pc: '0, s: '0,
                       flags: '0, vec: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy      = (seq_q.phase != PH_IDLE);
    assign done      = seq_q.done;
    assign pc_out    = seq_q.pc;
    assign s_out     = seq_q.s;
    assign flags_out = seq_q.flags;
endmodule

// File: rtl/intr_entry_chk.sv
module intr_entry_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cmos_mode,
    input logic           rw,
    input logic [AW-1:0]  addr,
    input logic           done,
    input logic           busy,
    input logic [DW-1:0]  flags_out
);
    // R1
    stack_page_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rw |-> addr[AW-1:DW] == 'h01);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_after_vec_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(rw) && $past(addr[0]) && ($past(addr[AW-1:DW]) == '1)));

    // R4
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> flags_out[2]);

    // R4
    cmos_dec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmos_mode) |-> !flags_out[3]);

    // R11
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R11
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> rw);
endmodule

bind intr_entry_seq intr_entry_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/intr_entry_seq_test.sv
`timescale 1ns/1ps
module intr_entry_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_boundary = 1'b0, brk_start = 1'b0;
    logic        irq_n = 1'b1, nmi_n = 1'b1, reset_req = 1'b0, cmos_mode = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  s_in = '0, flags_in = '0, din = '0;
    logic [15:0] addr, pc_out;
    logic [7:0]  dout, s_out, flags_out;
    logic        rw, busy, done;

    int checks = 0, failures = 0;
    bit finished = 0;

    typedef struct { logic [15:0] a; logic r; logic [7:0] d; } bus_t;
    bus_t exp_q[$];

    always #2 clk = ~clk;

    intr_entry_seq uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic kick(input logic brk);
        @(negedge clk);
        insn_boundary = 1'b1;
        brk_start     = brk;
        @(negedge clk);
        insn_boundary = 1'b0;
        brk_start     = 1'b0;
    endtask

    task automatic trace(input string tag, input bit is_brk, input bit is_rst,
                         input logic [15:0] vec, input logic [15:0] newpc, input bit nmi_mid);
        bus_t e;
        logic [15:0] ret;
        logic [7:0]  st, fexp, s1, s2, s3;
        ret  = is_brk ? pc_in + 16'd2 : pc_in;
        st   = (flags_in & 8'hEF) | 8'h20 | (is_brk ? 8'h10 : 8'h00);
        fexp = flags_in | 8'h04;
        if (cmos_mode) fexp = fexp & 8'hF7;
        s1 = s_in - 8'd1; s2 = s_in - 8'd2; s3 = s_in - 8'd3;
        exp_q.delete();
        exp_q.push_back('{pc_in, 1'b1, 8'h00});
        exp_q.push_back('{is_brk ? pc_in + 16'd1 : pc_in, 1'b1, 8'h00});
        exp_q.push_back('{{8'h01, s_in}, is_rst, ret[15:8]});
        exp_q.push_back('{{8'h01, s1}, is_rst, ret[7:0]});
        exp_q.push_back('{{8'h01, s2}, is_rst, st});
        exp_q.push_back('{vec, 1'b1, 8'h00});
        exp_q.push_back('{vec + 16'd1, 1'b1, 8'h00});
        for (int i = 0; i < 7; i++) begin
            e = exp_q.pop_front();
            chk({tag, " R1 R2 R5 addr"}, 32'(addr), 32'(e.a));
            chk({tag, " R9 rw"}, 32'(rw), 32'(e.r));
            if (!e.r) chk({tag, " R2 R3 dout"}, 32'(dout), 32'(e.d));
            if (i == 5) din = newpc[7:0];
            if (i == 6) din = newpc[15:8];
            if (nmi_mid && i == 1) nmi_n = 1'b0;
            @(negedge clk);
        end
        nmi_n = 1'b1;
        chk({tag, " R11 done"}, 32'(done), 32'd1);
        chk({tag, " R5 pc_out"}, 32'(pc_out), 32'(newpc));
        chk({tag, " R1 s_out"}, 32'(s_out), 32'(s3));
        chk({tag, " R4 flags_out"}, 32'(flags_out), 32'(fexp));
        @(negedge clk);
        chk({tag, " R11 done low"}, 32'(done), 32'd0);
        chk({tag, " R11 idle"}, 32'(busy), 32'd0);
    endtask

    task automatic no_start(input string tag);
        chk({tag, " busy"}, 32'(busy), 32'd0);
        @(negedge clk);
        chk({tag, " busy+1"}, 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset busy", 32'(busy), 32'd0);
        chk("R11 reset done", 32'(done), 32'd0);
        chk("R11 reset rw", 32'(rw), 32'd1);

        // R9 reset entry, older mode, D kept, stack wraps (R1)
        pc_in = 16'h4321; s_in = 8'h00; flags_in = 8'h08; cmos_mode = 1'b0;
        @(negedge clk); reset_req = 1'b1;
        @(negedge clk); reset_req = 1'b0;
        kick(1'b0);
        trace("R9 reset", 1'b0, 1'b1, 16'hFFFC, 16'hC000, 1'b0);

        // R8 maskable request, older mode
        pc_in = 16'h1234; s_in = 8'hFF; flags_in = 8'h09;
        @(negedge clk); irq_n = 1'b0;
        kick(1'b0); irq_n = 1'b1;
        trace("R8 irq", 1'b0, 1'b0, 16'hFFFE, 16'h8100, 1'b0);

        // R4 maskable request, newer mode clears D
        cmos_mode = 1'b1; flags_in = 8'h08; s_in = 8'h80;
        @(negedge clk); irq_n = 1'b0;
        kick(1'b0); irq_n = 1'b1;
        trace("R4 irq cmos", 1'b0, 1'b0, 16'hFFFE, 16'h8200, 1'b0);

        // R2 R3 break, older mode
        cmos_mode = 1'b0; pc_in = 16'h2000; s_in = 8'hF0; flags_in = 8'hC3;
        kick(1'b1);
        trace("R3 brk", 1'b1, 1'b0, 16'hFFFE, 16'h9000, 1'b0);

        // R8 non-maskable edge, newer mode
        cmos_mode = 1'b1; flags_in = 8'h08; pc_in = 16'h3456; s_in = 8'h40;
        @(negedge clk); nmi_n = 1'b0;
        kick(1'b0); nmi_n = 1'b1;
        trace("R8 nmi", 1'b0, 1'b0, 16'hFFFA, 16'hA000, 1'b0);

        // R6 older mode: NMI during break steals vector and is consumed
        cmos_mode = 1'b0; pc_in = 16'h5000; s_in = 8'hE0; flags_in = 8'h00;
        kick(1'b1);
        trace("R6 hijack", 1'b1, 1'b0, 16'hFFFA, 16'hB000, 1'b1);
        kick(1'b0);
        no_start("R6 nmi consumed");

        // R6 newer mode: break keeps its vector, NMI follows
        cmos_mode = 1'b1; pc_in = 16'h6000; s_in = 8'hD0;
        kick(1'b1);
        trace("R6 no hijack", 1'b1, 1'b0, 16'hFFFE, 16'hB100, 1'b1);
        kick(1'b0);
        trace("R6 nmi after brk", 1'b0, 1'b0, 16'hFFFA, 16'hB200, 1'b0);

        // R7 request arriving with the boundary is not taken
        cmos_mode = 1'b0; flags_in = 8'h00;
        @(negedge clk); irq_n = 1'b0; insn_boundary = 1'b1;
        @(negedge clk); insn_boundary = 1'b0; irq_n = 1'b1;
        no_start("R7 late irq");

        // R8 masked maskable request
        flags_in = 8'h04;
        @(negedge clk); irq_n = 1'b0;
        kick(1'b0);
        no_start("R8 masked irq");
        irq_n = 1'b1;

        // R10 break pulse without boundary
        flags_in = 8'h00;
        @(negedge clk); brk_start = 1'b1;
        @(negedge clk); brk_start = 1'b0;
        no_start("R10 brk no boundary");

        // R10 NMI beats IRQ
        pc_in = 16'h7000; s_in = 8'hC0;
        @(negedge clk); irq_n = 1'b0; nmi_n = 1'b0;
        kick(1'b1); irq_n = 1'b1; nmi_n = 1'b1;
        trace("R10 nmi over irq", 1'b0, 1'b0, 16'hFFFA, 16'hD000, 1'b0);

        // R10 reset beats NMI, NMI stays pending
        @(negedge clk); nmi_n = 1'b0; reset_req = 1'b1;
        @(negedge clk); reset_req = 1'b0; nmi_n = 1'b1;
        kick(1'b0);
        trace("R10 reset over nmi", 1'b0, 1'b1, 16'hFFFC, 16'hE000, 1'b0);
        kick(1'b0);
        trace("R10 deferred nmi", 1'b0, 1'b0, 16'hFFFA, 16'hE100, 1'b0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule